// File: doc/BRIEF.md
# SD Host Auto-Command Sequencer

This block orders the commands an SD host controller sends around a multi-block transfer. Software programs a transfer-mode word, an argument, a second 32-bit argument and a block count, then writes the command register. The sequencer hands one command at a time to a command-line engine over a start/response handshake. Depending on a 2-bit auto mode, it either sends a set-block-count command ahead of the programmed command or sends a stop command once the last data block has completed.

A failed set-block-count response cancels the programmed command. The cause is kept in a sticky error status with write-1-to-clear bits. Block-complete pulses from the data path decrement a counter that was loaded when the command was accepted. If counting is disabled, the transfer has no end and no stop command is produced. Further command writes are ignored while a sequence is in flight. A one-cycle done pulse marks the end of every sequence, whether it completed or was cancelled.

Top module: `sd_autocmd_seq`

## Requirements
- R1: Auto mode 2'b00 and 2'b11 both issue only the programmed command, with its index and argument, and no automatic command.
- R2: Auto mode 2'b10 first issues index 23 with the argument taken from `arg2_i`. The programmed command follows only after a good response.
- R3: If the index-23 response reports an error, the programmed command is never started, and status bits 0 (pre-command error) and 2 (command not issued) are set.
- R4: In auto mode 2'b01 with counting enabled and a nonzero count, index 12 with argument 0 is issued after the final block completes. An error in its response sets status bit 1.
- R5: With counting enabled, each `blk_done_i` pulse decrements `blk_left_o` by one, stopping at zero. The count is loaded from `blk_cnt_i` when the command write is accepted.
- R6: With counting disabled, `blk_done_i` leaves `blk_left_o` unchanged, and no index-12 command is produced.
- R7: A loaded count of zero produces no data phase and no index-12 command.
- R8: `busy_o` is high from acceptance to the end of the sequence. A command write while busy is ignored: no DMA start, and the latched index and arguments do not change.
- R9: Status bits are sticky until a 1 is written to the same bit of `err_clr_i`. Clearing one bit leaves the others unchanged.
- R10: `seq_done_o` pulses for exactly one cycle as the sequence ends, normally or by cancellation, with `busy_o` low in that cycle.
- R11: An accepted write with `dma_en_i` high produces a one-cycle `dma_start_o` pulse. `xfer_read_o` holds the latched direction bit (1 = card to host) while `xfer_active_o` marks the data phase.
- R12: The programmed command index is not checked. Any 6-bit value, including 12 and 23, is forwarded unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| xfer_dir_i | input | 1 | Direction: 1 card-to-host, 0 host-to-card |
| auto_mode_i | input | 2 | Auto-command mode |
| blk_cnt_en_i | input | 1 | Enable block counting |
| dma_en_i | input | 1 | Start DMA on command write |
| cmd_wr_i | input | 1 | Write strobe for the command register upper byte |
| cmd_idx_i | input | 6 | Programmed command index |
| cmd_arg_i | input | 32 | Programmed command argument |
| arg2_i | input | 32 | Argument for the set-block-count command |
| blk_cnt_i | input | 16 | Block count loaded on acceptance |
| blk_done_i | input | 1 | Block-complete pulse from the data path |
| eng_rsp_done_i | input | 1 | Response received from the command engine |
| eng_rsp_err_i | input | 1 | Response error, qualified by done |
| err_clr_i | input | 3 | Write-1-to-clear for the status bits |
| eng_start_o | output | 1 | One-cycle command start |
| eng_idx_o | output | 6 | Command index to the engine |
| eng_arg_o | output | 32 | Command argument to the engine |
| busy_o | output | 1 | Sequence in flight |
| seq_done_o | output | 1 | End-of-sequence pulse |
| dma_start_o | output | 1 | DMA start pulse |
| xfer_active_o | output | 1 | Data phase awaiting the final block |
| xfer_read_o | output | 1 | Latched direction |
| blk_left_o | output | 16 | Remaining block count |
| err_stat_o | output | 3 | Sticky status: bit0 pre error, bit1 stop error, bit2 not issued |

## Verification
The hardest case to reach is a command write that arrives while a sequence is already running, particularly during the wait for the set-block-count response. That is the moment an accepted write would overwrite the queued index. In every sequence, the bench writes a different index, with DMA requested, right after the first start it sees, and then checks both that no DMA pulse appears and that the original index is issued. It also sweeps all four modes, both counting settings, counts of 0, 1 and 3, and every response-error combination, which covers the stop command that follows the final decrement and the cancellation path.

// File: rtl/sd_autocmd_pkg.sv
package sd_autocmd_pkg;
  localparam int unsigned CMD_IDX_W   = 6;
  localparam int unsigned CMD_ARG_W   = 32;
  localparam int unsigned ERR_W       = 3;
  localparam int unsigned ERR_PRE     = 0;
  localparam int unsigned ERR_STOP    = 1;
  localparam int unsigned ERR_NOISS   = 2;
  localparam logic [CMD_IDX_W-1:0] IDX_SET_CNT = 6'd23;
  localparam logic [CMD_IDX_W-1:0] IDX_STOP    = 6'd12;

  typedef enum logic [1:0] {
    AM_NONE = 2'b00,
    AM_STOP = 2'b01,
    AM_PRE  = 2'b10,
    AM_RSVD = 2'b11
  } auto_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE_ISS, ST_PRE_WAIT, ST_USR_ISS,
    ST_USR_WAIT, ST_DATA, ST_STOP_ISS, ST_STOP_WAIT
  } seq_state_e;

  typedef enum logic [1:0] {
    SEL_USR, SEL_PRE, SEL_STOP
  } cmd_sel_e;
endpackage

// File: rtl/sd_blk_counter.sv
module sd_blk_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] count_o,
  output logic             zero_o,
  output logic             en_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
      en_q  <= en_i;
    end else if (en_q && step_i && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign count_o = cnt_q;
  assign zero_o  = (cnt_q == '0);
  assign en_o    = en_q;
endmodule

// File: rtl/sd_autocmd_err.sv
module sd_autocmd_err #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q;

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr_i) | set_i;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/sd_autocmd_fsm.sv
module sd_autocmd_fsm
  import sd_autocmd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_wr_i,
  input  logic [1:0] mode_i,
  input  logic       cnt_en_i,
  input  logic       cnt_zero_i,
  input  logic       rsp_done_i,
  input  logic       rsp_err_i,
  output logic       busy_o,
  output logic       accept_o,
  output logic       start_o,
  output cmd_sel_e   sel_o,
  output logic       xfer_active_o,
  output logic       in_stop_o,
  output logic       done_o,
  output logic       set_pre_err_o,
  output logic       set_stop_err_o,
  output logic       set_noiss_o
);
  seq_state_e state_q, state_d;
  auto_mode_e mode_q;
  logic       done_q;
  logic       go_data;
  logic       finish;

  assign accept_o = (state_q == ST_IDLE) && cmd_wr_i;
  assign go_data  = (mode_q == AM_STOP) && cnt_en_i && !cnt_zero_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (accept_o)
                      state_d = (auto_mode_e'(mode_i) == AM_PRE) ? ST_PRE_ISS : ST_USR_ISS;
      ST_PRE_ISS:   state_d = ST_PRE_WAIT;
      ST_PRE_WAIT:  if (rsp_done_i) state_d = rsp_err_i ? ST_IDLE : ST_USR_ISS;
      ST_USR_ISS:   state_d = ST_USR_WAIT;
      ST_USR_WAIT:  if (rsp_done_i) state_d = go_data ? ST_DATA : ST_IDLE;
      ST_DATA:      if (cnt_zero_i) state_d = ST_STOP_ISS;
      ST_STOP_ISS:  state_d = ST_STOP_WAIT;
      ST_STOP_WAIT: if (rsp_done_i) state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  assign set_pre_err_o  = (state_q == ST_PRE_WAIT) && rsp_done_i && rsp_err_i;
  assign set_noiss_o    = set_pre_err_o;
  assign set_stop_err_o = (state_q == ST_STOP_WAIT) && rsp_done_i && rsp_err_i;
  assign finish = set_pre_err_o
               || ((state_q == ST_USR_WAIT) && rsp_done_i && !go_data)
               || ((state_q == ST_STOP_WAIT) && rsp_done_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= AM_NONE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= finish;
      if (accept_o) mode_q <= auto_mode_e'(mode_i);
    end
  end

  always_comb begin
    unique case (state_q)
      ST_PRE_ISS:  sel_o = SEL_PRE;
      ST_STOP_ISS: sel_o = SEL_STOP;
      default:     sel_o = SEL_USR;
    endcase
  end

  assign start_o       = (state_q == ST_PRE_ISS) || (state_q == ST_USR_ISS)
                      || (state_q == ST_STOP_ISS);
  assign busy_o        = (state_q != ST_IDLE);
  assign xfer_active_o = (state_q == ST_DATA);
  assign in_stop_o     = (state_q == ST_STOP_ISS);
  assign done_o        = done_q;
endmodule

// File: rtl/sd_autocmd_seq.sv
module sd_autocmd_seq
  import sd_autocmd_pkg::*;
#(
  parameter int unsigned BLK_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 xfer_dir_i,
  input  logic [1:0]           auto_mode_i,
  input  logic                 blk_cnt_en_i,
  input  logic                 dma_en_i,
  input  logic                 cmd_wr_i,
  input  logic [CMD_IDX_W-1:0] cmd_idx_i,
  input  logic [CMD_ARG_W-1:0] cmd_arg_i,
  input  logic [CMD_ARG_W-1:0] arg2_i,
  input  logic [BLK_W-1:0]     blk_cnt_i,
  input  logic                 blk_done_i,
  input  logic                 eng_rsp_done_i,
  input  logic                 eng_rsp_err_i,
  input  logic [ERR_W-1:0]     err_clr_i,
  output logic                 eng_start_o,
  output logic [CMD_IDX_W-1:0] eng_idx_o,
  output logic [CMD_ARG_W-1:0] eng_arg_o,
  output logic                 busy_o,
  output logic                 seq_done_o,
  output logic                 dma_start_o,
  output logic                 xfer_active_o,
  output logic                 xfer_read_o,
  output logic [BLK_W-1:0]     blk_left_o,
  output logic [ERR_W-1:0]     err_stat_o
);
  logic                 cmd_accept;
  logic                 cnt_en;
  logic                 cnt_zero;
  logic                 in_stop;
  logic                 set_pre, set_stop, set_noiss;
  cmd_sel_e             sel;
  logic [CMD_IDX_W-1:0] idx_q;
  logic [CMD_ARG_W-1:0] arg_q, arg2_q;
  logic                 dir_q, dma_q;
  logic [ERR_W-1:0]     err_set;

  sd_blk_counter #(.CNT_W(BLK_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cmd_accept),
    .en_i       (blk_cnt_en_i),
    .load_val_i (blk_cnt_i),
    .step_i     (blk_done_i),
    .count_o    (blk_left_o),
    .zero_o     (cnt_zero),
    .en_o       (cnt_en)
  );

  sd_autocmd_fsm u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cmd_wr_i       (cmd_wr_i),
    .mode_i         (auto_mode_i),
    .cnt_en_i       (cnt_en),
    .cnt_zero_i     (cnt_zero),
    .rsp_done_i     (eng_rsp_done_i),
    .rsp_err_i      (eng_rsp_err_i),
    .busy_o         (busy_o),
    .accept_o       (cmd_accept),
    .start_o        (eng_start_o),
    .sel_o          (sel),
    .xfer_active_o  (xfer_active_o),
    .in_stop_o      (in_stop),
    .done_o         (seq_done_o),
    .set_pre_err_o  (set_pre),
    .set_stop_err_o (set_stop),
    .set_noiss_o    (set_noiss)
  );

  always_comb begin
    err_set            = '0;
    err_set[ERR_PRE]   = set_pre;
    err_set[ERR_STOP]  = set_stop;
    err_set[ERR_NOISS] = set_noiss;
  end

  sd_autocmd_err #(.W(ERR_W)) u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (err_set),
    .clr_i  (err_clr_i),
    .stat_o (err_stat_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      arg_q  <= '0;
      arg2_q <= '0;
      dir_q  <= 1'b0;
      dma_q  <= 1'b0;
    end else begin
      dma_q <= cmd_accept && dma_en_i;
      if (cmd_accept) begin
        idx_q  <= cmd_idx_i;
        arg_q  <= cmd_arg_i;
        arg2_q <= arg2_i;
        dir_q  <= xfer_dir_i;
      end
    end
  end

  always_comb begin
    unique case (sel)
      SEL_PRE:  begin eng_idx_o = IDX_SET_CNT; eng_arg_o = arg2_q; end
      SEL_STOP: begin eng_idx_o = IDX_STOP;    eng_arg_o = '0;     end
      default:  begin eng_idx_o = idx_q;       eng_arg_o = arg_q;  end
    endcase
  end

  assign dma_start_o = dma_q;
  assign xfer_read_o = dir_q;
endmodule

// File: rtl/sd_autocmd_seq_chk.sv
module sd_autocmd_seq_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             eng_start_o,
  input logic             busy_o,
  input logic             seq_done_o,
  input logic             dma_start_o,
  input logic             cmd_wr_i,
  input logic             blk_done_i,
  input logic [CNT_W-1:0] blk_left_o,
  input logic [2:0]       err_stat_o,
  input logic [2:0]       err_clr_i,
  input logic             cnt_en,
  input logic             cmd_accept,
  input logic             in_stop
);
  p_start_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |-> busy_o);
  p_start_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |=> !eng_start_o);
  p_stop_last_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_start_o && in_stop) |-> (cnt_en && blk_left_o == '0));
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_en && !cmd_accept) |=> $stable(blk_left_o));
  p_dec_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en && !cmd_accept && blk_done_i && blk_left_o != '0)
      |=> blk_left_o == $past(blk_left_o) - 1'b1);
  p_sticky_pre_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_stat_o[0] && !err_clr_i[0]) |=> err_stat_o[0]);
  p_sticky_stop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_stat_o[1] && !err_clr_i[1]) |=> err_stat_o[1]);
  p_done_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_done_o |-> !busy_o);
  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_done_o |=> !seq_done_o);
  p_ignore_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cmd_wr_i) |=> !dma_start_o);
endmodule

bind sd_autocmd_seq sd_autocmd_seq_chk #(.CNT_W(BLK_W)) u_chk (.*);

// File: tb/sd_autocmd_seq_tb.sv
module sd_autocmd_seq_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        xfer_dir_i = 1'b0;
  logic [1:0]  auto_mode_i = '0;
  logic        blk_cnt_en_i = 1'b0;
  logic        dma_en_i = 1'b0;
  logic        cmd_wr_i = 1'b0;
  logic [5:0]  cmd_idx_i = '0;
  logic [31:0] cmd_arg_i = '0;
  logic [31:0] arg2_i = '0;
  logic [15:0] blk_cnt_i = '0;
  logic        blk_done_i = 1'b0;
  logic        eng_rsp_done_i = 1'b0;
  logic        eng_rsp_err_i = 1'b0;
  logic [2:0]  err_clr_i = '0;
  logic        eng_start_o;
  logic [5:0]  eng_idx_o;
  logic [31:0] eng_arg_o;
  logic        busy_o, seq_done_o, dma_start_o, xfer_active_o, xfer_read_o;
  logic [15:0] blk_left_o;
  logic [2:0]  err_stat_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk_i = ~clk_i;

  sd_autocmd_seq u_dut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_start(output bit got);
    got = 1'b0;
    for (int k = 0; k < 40; k++) begin
      if (eng_start_o) begin got = 1'b1; break; end
      @(negedge clk_i);
    end
  endtask

  task automatic respond(input bit e);
    @(negedge clk_i);
    eng_rsp_done_i = 1'b1; eng_rsp_err_i = e;
    @(negedge clk_i);
    eng_rsp_done_i = 1'b0; eng_rsp_err_i = 1'b0;
  endtask

  // busy-time write with a different index, then the response
  task automatic poke_respond(input bit e);
    cmd_wr_i = 1'b1; cmd_idx_i = 6'd5; dma_en_i = 1'b1;
    @(negedge clk_i);
    cmd_wr_i = 1'b0; dma_en_i = 1'b0;
    chk(dma_start_o == 1'b0, "R8 no dma on busy write", dma_start_o, 0);
    chk(busy_o == 1'b1, "R8 busy held", busy_o, 1);
    eng_rsp_done_i = 1'b1; eng_rsp_err_i = e;
    @(negedge clk_i);
    eng_rsp_done_i = 1'b0; eng_rsp_err_i = 1'b0;
  endtask

  task automatic check_done();
    chk(seq_done_o == 1'b1, "R10 done pulse", seq_done_o, 1);
    chk(busy_o == 1'b0, "R10 idle at done", busy_o, 0);
    @(negedge clk_i);
    chk(seq_done_o == 1'b0, "R10 done one cycle", seq_done_o, 0);
  endtask

  task automatic no_start(input int n, input string req);
    bit seen = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      if (eng_start_o) seen = 1'b1;
    end
    chk(!seen, req, seen, 0);
  endtask

  task automatic run_case(input int mode, input bit bc, input int cnt,
                          input bit e23, input bit e12, input int n);
    bit got;
    bit dma = n[0];
    bit dir = n[1];
    logic [5:0]  uidx = 6'((n * 7 + 3) % 64);
    logic [31:0] uarg = 32'hA500_0000 | 32'(n);
    logic [31:0] a2   = 32'h1000_0000 + 32'(n * 3);
    bit stop_exp = (mode == 1) && bc && (cnt != 0);
    logic [2:0] exp_err;

    auto_mode_i = 2'(mode); blk_cnt_en_i = bc; blk_cnt_i = 16'(cnt);
    xfer_dir_i = dir; dma_en_i = dma; cmd_idx_i = uidx; cmd_arg_i = uarg; arg2_i = a2;
    cmd_wr_i = 1'b1;
    @(negedge clk_i);
    cmd_wr_i = 1'b0; dma_en_i = 1'b0;
    chk(dma_start_o == dma, "R11 dma start", dma_start_o, dma);
    chk(busy_o == 1'b1, "R8 busy after accept", busy_o, 1);

    if (mode == 2) begin
      wait_start(got);
      chk(got && eng_idx_o == 6'd23, "R2 pre idx", eng_idx_o, 23);
      chk(eng_arg_o == a2, "R2 pre arg from arg2", eng_arg_o, a2);
      poke_respond(e23);
      if (e23) begin
        check_done();
        chk(err_stat_o == 3'b101, "R3 pre error status", err_stat_o, 5);
        no_start(6, "R3 user command suppressed");
        exp_err = 3'b101;
      end
    end

    if (!(mode == 2 && e23)) begin
      wait_start(got);
      chk(got && eng_idx_o == uidx, "R12 user idx unchecked", eng_idx_o, uidx);
      chk(eng_arg_o == uarg, "R1 user arg", eng_arg_o, uarg);
      if (mode != 2) poke_respond(1'b0);
      else           respond(1'b0);
      if (stop_exp) begin
        chk(xfer_active_o == 1'b1, "R11 data phase", xfer_active_o, 1);
        chk(xfer_read_o == dir, "R11 direction", xfer_read_o, dir);
        for (int i = 0; i < cnt; i++) begin
          chk(blk_left_o == 16'(cnt - i), "R5 count down", blk_left_o, cnt - i);
          chk(!eng_start_o, "R4 no early stop", eng_start_o, 0);
          blk_done_i = 1'b1;
          @(negedge clk_i);
          blk_done_i = 1'b0;
        end
        chk(blk_left_o == 16'd0, "R5 reaches zero", blk_left_o, 0);
        wait_start(got);
        chk(got && eng_idx_o == 6'd12, "R4 stop idx", eng_idx_o, 12);
        chk(eng_arg_o == 32'd0, "R4 stop arg", eng_arg_o, 0);
        respond(e12);
        check_done();
        exp_err = {1'b0, e12, 1'b0};
        chk(err_stat_o == exp_err, "R4 stop error status", err_stat_o, exp_err);
      end else begin
        check_done();
        exp_err = 3'b000;
        chk(err_stat_o == 3'b000, "R1 no error", err_stat_o, 0);
        no_start(5, (cnt == 0) ? "R7 no stop for zero count" : "R6 no stop without counting");
        if (!bc) begin
          for (int i = 0; i < 2; i++) begin
            blk_done_i = 1'b1;
            @(negedge clk_i);
            blk_done_i = 1'b0;
          end
          chk(blk_left_o == 16'(cnt), "R6 count held", blk_left_o, cnt);
        end
      end
    end

    if (exp_err != 3'b000) begin
      repeat (2) @(negedge clk_i);
      chk(err_stat_o == exp_err, "R9 sticky", err_stat_o, exp_err);
      err_clr_i = 3'b001;
      @(negedge clk_i);
      err_clr_i = 3'b000;
      chk(err_stat_o == (exp_err & 3'b110), "R9 partial clear", err_stat_o, exp_err & 3'b110);
      err_clr_i = 3'b111;
      @(negedge clk_i);
      err_clr_i = 3'b000;
      chk(err_stat_o == 3'b000, "R9 full clear", err_stat_o, 0);
    end
  endtask

  initial begin
    int n = 0;
    int cnts[3] = '{0, 1, 3};
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(busy_o == 1'b0 && eng_start_o == 1'b0, "R8 reset idle", busy_o, 0);
    chk(err_stat_o == 3'b000, "R9 reset status", err_stat_o, 0);
    chk(seq_done_o == 1'b0 && dma_start_o == 1'b0, "R10 reset pulses", seq_done_o, 0);
    for (int m = 0; m < 4; m++)
      for (int b = 0; b < 2; b++)
        for (int c = 0; c < 3; c++)
          for (int e = 0; e < 4; e++) begin
            run_case(m, b[0], cnts[c], e[0], e[1], n);
            n++;
            @(negedge clk_i);
          end
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule